// File: doc/BRIEF.md
# Port change-detection interrupt controller

This block watches a group of byte-wide input ports and raises a single interrupt line when a selected pin changes level. Each pin can be armed separately for rising and for falling transitions. Two global polarity switches sit on top of the per-pin masks, so software can suspend one kind of transition without rewriting every mask. All pins pass through a two-flop synchronizer before the transition is detected.

A sticky edge flag records the first qualified transition. A second qualified transition that arrives before software clears the edge flag sets a sticky overflow flag. Software reads both flags and a pending bit from a status register. It acknowledges them through a write-one-to-clear register. The pending bit equals the interrupt output, so a handler on a shared line can tell whether this block is asserting it. Software reaches the registers through a simple byte-wide bus: address, write data, write strobe, and combinational read data.

Top module: `chg_irq_ctrl`

## Requirements
- R1: After reset every enable register, the control register and both flags are zero, status reads 0x00 and irq_o is low.
- R2: The rising-enable byte of port p is at address 0x42+0x10*p and the falling-enable byte at 0x43+0x10*p. Both read back what was written. Unmapped addresses and the clear register (0x01) read 0x00.
- R3: A 0-to-1 change on a pin whose rising-enable bit is set, while control bit 3 (global rising) is set, sets the edge flag (status bit 0). The flag is first visible after the third rising clock edge following the change, and not after the first or second.
- R4: A 1-to-0 change on a pin whose falling-enable bit is set, while control bit 4 (global falling) is set, sets the edge flag with the same latency.
- R5: A change whose per-pin enable for that polarity is clear, or whose global polarity bit is clear, leaves both flags unchanged.
- R6: A qualified change that arrives while the edge flag is already set sets the overflow flag (status bit 1).
- R7: A write to address 0x01 with bit 3 set clears the edge flag and with bit 2 set clears the overflow flag. Both can be cleared in one write. If a qualified change lands in the same cycle as an edge-clear, the edge flag stays set and overflow is not set.
- R8: irq_o is high exactly when control bit 2 (master) is set and either the edge flag with control bit 0, or the overflow flag with control bit 1, is set. Status bit 2 always equals irq_o.
- R9: Writing 0x00 to the control register (0x03) drops irq_o from the next cycle on and leaves the flags intact.
- R10: The control register reads back its five defined bits, with bits 7..5 reading as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pins_i | input | NUM_PORTS*PORT_W (32) | Asynchronous input pins, port p in bits [8p+7:8p] |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that bus_we is a single-cycle pulse with bus_addr and bus_wdata steady in that cycle. They also assume pins_i is stable across the sampling edge, so the synchronizer never resolves metastability into a different value. The bench changes pins and bus signals only on the falling clock edge and keeps each write strobe to exactly one cycle. The same-cycle clear-versus-edge race is therefore reached by counting clock edges rather than by skewing inputs.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    // Register addresses that software decodes
    localparam logic [ADDR_W-1:0] CLR_OFS     = 8'h01;
    localparam logic [ADDR_W-1:0] STAT_OFS    = 8'h02;
    localparam logic [ADDR_W-1:0] CTRL_OFS    = 8'h03;
    localparam logic [ADDR_W-1:0] RISE_BASE   = 8'h42;
    localparam logic [ADDR_W-1:0] FALL_BASE   = 8'h43;
    localparam logic [ADDR_W-1:0] PORT_STRIDE = 8'h10;

    // Bit positions inside the clear and status bytes
    localparam int CLR_EDGE_BIT = 3;
    localparam int CLR_OVF_BIT  = 2;
    localparam int STAT_EDGE    = 0;
    localparam int STAT_OVF     = 1;
    localparam int STAT_PEND    = 2;
    localparam int CTRL_W       = 5;

    // Control byte, packed MSB first so that bit 0 is edge_ie
    typedef struct packed {
        logic fall_all;   // bit 4: global falling-edge enable
        logic rise_all;   // bit 3: global rising-edge enable
        logic master;     // bit 2: master interrupt enable
        logic ovf_ie;     // bit 1: overflow interrupt enable
        logic edge_ie;    // bit 0: edge interrupt enable
    } ctrl_t;

    function automatic logic [ADDR_W-1:0] rise_addr(input int p);
        return RISE_BASE + ADDR_W'(p) * PORT_STRIDE;
    endfunction

    function automatic logic [ADDR_W-1:0] fall_addr(input int p);
        return FALL_BASE + ADDR_W'(p) * PORT_STRIDE;
    endfunction

endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout_o = stg_q[STAGES-1];

endmodule

// File: rtl/chg_edge_qual.sv
module chg_edge_qual #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] rise_en_i,
    input  logic [W-1:0] fall_en_i,
    input  logic         rise_all_i,
    input  logic         fall_all_i,
    output logic         hit_o
);

    typedef struct packed {
        logic [W-1:0] prev;
    } qual_t;

    qual_t st_d, st_q;
    logic [W-1:0] up, down;

    always_comb begin
        st_d      = st_q;
        st_d.prev = cur_i;
        up        = cur_i & ~st_q.prev & rise_en_i & {W{rise_all_i}};
        down      = ~cur_i & st_q.prev & fall_en_i & {W{fall_all_i}};
        hit_o     = |(up | down);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/chg_regs.sv
module chg_regs
    import chg_irq_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [ADDR_W-1:0]                  addr_i,
    input  logic [DATA_W-1:0]                  wdata_i,
    input  logic                               we_i,
    input  logic [DATA_W-1:0]                  status_i,
    output logic [DATA_W-1:0]                  rdata_o,
    output logic [NUM_PORTS-1:0][PORT_W-1:0]   rise_en_o,
    output logic [NUM_PORTS-1:0][PORT_W-1:0]   fall_en_o,
    output ctrl_t                              ctrl_o,
    output logic                               clr_edge_o,
    output logic                               clr_ovf_o
);

    typedef struct packed {
        logic [NUM_PORTS-1:0][PORT_W-1:0] rise;
        logic [NUM_PORTS-1:0][PORT_W-1:0] fall;
        ctrl_t                            ctrl;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        clr_edge_o = 1'b0;
        clr_ovf_o  = 1'b0;
        if (we_i) begin
            if (addr_i == CTRL_OFS) begin
                st_d.ctrl = ctrl_t'(wdata_i[CTRL_W-1:0]);
            end
            if (addr_i == CLR_OFS) begin
                clr_edge_o = wdata_i[CLR_EDGE_BIT];
                clr_ovf_o  = wdata_i[CLR_OVF_BIT];
            end
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (addr_i == rise_addr(p)) st_d.rise[p] = wdata_i[PORT_W-1:0];
                if (addr_i == fall_addr(p)) st_d.fall[p] = wdata_i[PORT_W-1:0];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == CTRL_OFS) rdata_o = DATA_W'(st_q.ctrl);
        if (addr_i == STAT_OFS) rdata_o = status_i;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (addr_i == rise_addr(p)) rdata_o = DATA_W'(st_q.rise[p]);
            if (addr_i == fall_addr(p)) rdata_o = DATA_W'(st_q.fall[p]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_en_o = st_q.rise;
    assign fall_en_o = st_q.fall;
    assign ctrl_o    = st_q.ctrl;

endmodule

// File: rtl/chg_irq_ctrl.sv
module chg_irq_ctrl
    import chg_irq_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    input  logic                          bus_we,
    output logic [DATA_W-1:0]             bus_rdata,
    input  logic [NUM_PORTS*PORT_W-1:0]   pins_i,
    output logic                          irq_o
);

    localparam int PIN_W = NUM_PORTS * PORT_W;

    typedef struct packed {
        logic edge_seen;
        logic ovf_seen;
    } flags_t;

    flags_t flags_d, flags_q;

    logic [PIN_W-1:0]                 pins_s;
    logic [NUM_PORTS-1:0]             hit_vec;
    logic [NUM_PORTS-1:0][PORT_W-1:0] rise_en, fall_en;
    ctrl_t                            ctrl;
    logic                             clr_edge, clr_ovf;
    logic [DATA_W-1:0]                status;

    // Signals exposed to the bound checker
    logic hit_any, edge_flag, ovf_flag, master_en;

    chg_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (pins_i),
        .dout_o (pins_s)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        chg_edge_qual #(
            .W (PORT_W)
        ) u_qual (
            .clk        (clk),
            .rst_n      (rst_n),
            .cur_i      (pins_s[p*PORT_W +: PORT_W]),
            .rise_en_i  (rise_en[p]),
            .fall_en_i  (fall_en[p]),
            .rise_all_i (ctrl.rise_all),
            .fall_all_i (ctrl.fall_all),
            .hit_o      (hit_vec[p])
        );
    end

    chg_regs #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .we_i       (bus_we),
        .status_i   (status),
        .rdata_o    (bus_rdata),
        .rise_en_o  (rise_en),
        .fall_en_o  (fall_en),
        .ctrl_o     (ctrl),
        .clr_edge_o (clr_edge),
        .clr_ovf_o  (clr_ovf)
    );

    assign hit_any = |hit_vec;

    // A new hit dominates a same-cycle clear so no event is lost
    always_comb begin
        flags_d           = flags_q;
        flags_d.edge_seen = hit_any | (flags_q.edge_seen & ~clr_edge);
        flags_d.ovf_seen  = (hit_any & flags_q.edge_seen & ~clr_edge)
                          | (flags_q.ovf_seen & ~clr_ovf);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign irq_o = ctrl.master & ((flags_q.edge_seen & ctrl.edge_ie)
                                | (flags_q.ovf_seen  & ctrl.ovf_ie));

    always_comb begin
        status            = '0;
        status[STAT_EDGE] = flags_q.edge_seen;
        status[STAT_OVF]  = flags_q.ovf_seen;
        status[STAT_PEND] = irq_o;
    end

    assign edge_flag = flags_q.edge_seen;
    assign ovf_flag  = flags_q.ovf_seen;
    assign master_en = ctrl.master;

endmodule

// File: rtl/chg_irq_ctrl_chk.sv
module chg_irq_ctrl_chk
    import chg_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_o,
    input logic              hit_any,
    input logic              edge_flag,
    input logic              ovf_flag,
    input logic              master_en
);

    logic clr_wr;
    assign clr_wr = bus_we && (bus_addr == CLR_OFS);

    // R3 / R4: a qualified hit always leaves the edge flag set
    p_hit_sets_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |=> edge_flag);

    // R5: without a hit or a clear write the flags hold
    p_flags_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_any && !clr_wr) |=> ($stable(edge_flag) && $stable(ovf_flag)));

    // R6: overflow only rises while an edge is recorded
    p_ovf_with_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> edge_flag);

    // R7: an edge clear without a competing hit empties the edge flag
    p_edge_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && bus_wdata[CLR_EDGE_BIT] && !hit_any) |=> !edge_flag);

    // R8: no interrupt without master enable
    p_irq_master_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> master_en);

    // R8: pending status bit mirrors the interrupt line
    p_pend_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == STAT_OFS) |-> (bus_rdata[STAT_PEND] == irq_o));

    // R9: a zero control write silences the line
    p_ctrl_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == CTRL_OFS && bus_wdata == '0) |=> !irq_o);

endmodule

bind chg_irq_ctrl chg_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .hit_any   (hit_any),
    .edge_flag (edge_flag),
    .ovf_flag  (ovf_flag),
    .master_en (master_en)
);

// File: tb/chg_irq_ctrl_tb.sv
`timescale 1ns/1ps
module chg_irq_ctrl_tb;

    localparam int NP = 4;
    localparam int PW = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_we;
    logic [7:0]  bus_rdata;
    logic [NP*PW-1:0] pins;
    logic        irq_o;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    chg_irq_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .pins_i    (pins),
        .irq_o     (irq_o)
    );

    function automatic logic [7:0] rise_a(int p);
        return 8'h42 + 8'(p) * 8'h10;
    endfunction
    function automatic logic [7:0] fall_a(int p);
        return 8'h43 + 8'(p) * 8'h10;
    endfunction

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1 check(bus_rdata, exp, tag);
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        @(negedge clk);
        #1 check({7'd0, irq_o}, {7'd0, exp}, tag);
    endtask

    task automatic flip(input int idx);
        @(negedge clk);
        pins[idx] = ~pins[idx];
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; pins = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        irq_chk(1'b0, "R1 irq");
        rd(8'h02, 8'h00, "R1 status");
        rd(8'h03, 8'h00, "R1 ctrl");
        for (int p = 0; p < NP; p++) begin
            rd(rise_a(p), 8'h00, "R1 rise");
            rd(fall_a(p), 8'h00, "R1 fall");
        end

        // R2 enable register readback and unmapped reads
        for (int p = 0; p < NP; p++) begin
            wr(rise_a(p), 8'h5A ^ 8'(p * 17));
            wr(fall_a(p), 8'hC3 + 8'(p * 29));
        end
        for (int p = 0; p < NP; p++) begin
            rd(rise_a(p), 8'h5A ^ 8'(p * 17), "R2 rise");
            rd(fall_a(p), 8'hC3 + 8'(p * 29), "R2 fall");
        end
        rd(8'h00, 8'h00, "R2 unmapped");
        rd(8'h01, 8'h00, "R2 clear reg");
        rd(8'h40, 8'h00, "R2 unmapped");
        rd(8'h44, 8'h00, "R2 unmapped");
        rd(8'h82, 8'h00, "R2 beyond ports");
        for (int p = 0; p < NP; p++) begin
            wr(rise_a(p), 8'h00);
            wr(fall_a(p), 8'h00);
        end

        // R10 control readback
        wr(8'h03, 8'hFF);
        rd(8'h03, 8'h1F, "R10 ctrl");
        wr(8'h03, 8'h00);

        // Sweep every pin and polarity: R3 R4 R5 R6 R7 R8
        wr(8'h03, 8'h1F);
        for (int p = 0; p < NP; p++) begin
            for (int b = 0; b < PW; b++) begin
                for (int pol = 0; pol < 2; pol++) begin
                    int idx;
                    logic [7:0] ra;
                    idx = p * PW + b;
                    ra = (pol == 0) ? rise_a(p) : fall_a(p);
                    if (pins[idx] != pol[0]) begin
                        flip(idx);
                        settle();
                    end
                    wr(8'h01, 8'h0C);
                    wr(ra, 8'(1 << b));
                    flip(idx);
                    rd(8'h02, 8'h00, "R3 sync stage 1");
                    rd(8'h02, 8'h00, "R3 sync stage 2");
                    rd(8'h02, 8'h05, (pol == 0) ? "R3 rising" : "R4 falling");
                    irq_chk(1'b1, "R8 edge irq");
                    flip(idx);
                    settle();
                    rd(8'h02, 8'h05, "R5 opposite polarity");
                    flip(idx);
                    settle();
                    rd(8'h02, 8'h07, "R6 overflow");
                    wr(8'h01, 8'h08);
                    rd(8'h02, 8'h06, "R7 edge clear");
                    wr(8'h01, 8'h04);
                    rd(8'h02, 8'h00, "R7 ovf clear");
                    irq_chk(1'b0, "R8 idle irq");
                    wr(ra, 8'h00);
                end
            end
        end

        // R5 other-bit enable and global polarity gating (pin 0 of port 0)
        wr(8'h01, 8'h0C);
        wr(rise_a(0), 8'h02);
        wr(fall_a(0), 8'h02);
        if (pins[0]) begin flip(0); settle(); end
        flip(0); settle();
        rd(8'h02, 8'h00, "R5 other bit rise");
        flip(0); settle();
        rd(8'h02, 8'h00, "R5 other bit fall");
        wr(rise_a(0), 8'h01);
        wr(fall_a(0), 8'h01);
        wr(8'h03, 8'h07);
        flip(0); settle();
        rd(8'h02, 8'h00, "R5 global rise off");
        flip(0); settle();
        rd(8'h02, 8'h00, "R5 global fall off");

        // R7 hit in the same cycle as an edge clear
        wr(fall_a(0), 8'h00);
        wr(8'h03, 8'h1F);
        flip(0); settle();
        rd(8'h02, 8'h05, "R3 set before race");
        flip(0); settle();
        flip(0);
        @(posedge clk);
        @(posedge clk);
        wr(8'h01, 8'h08);
        rd(8'h02, 8'h05, "R7 hit beats clear");
        flip(0); settle();
        flip(0); settle();
        rd(8'h02, 8'h07, "R6 second hit");
        wr(8'h01, 8'h0C);
        rd(8'h02, 8'h00, "R7 joint clear");

        // R9 and R8 gating with edge flag set
        flip(0); settle();
        flip(0); settle();
        rd(8'h02, 8'h05, "R3 reset flag");
        wr(8'h03, 8'h00);
        irq_chk(1'b0, "R9 ctrl zero irq");
        rd(8'h02, 8'h01, "R9 flag kept");
        wr(8'h03, 8'h04);
        irq_chk(1'b0, "R8 master only");
        wr(8'h03, 8'h05);
        irq_chk(1'b1, "R8 master and edge_ie");
        wr(8'h03, 8'h01);
        irq_chk(1'b0, "R8 no master");
        wr(8'h03, 8'h06);
        irq_chk(1'b0, "R8 ovf_ie without ovf");

        finish_run();
    end

endmodule